// File: doc/BRIEF.md
# Fractional-Rate Result Serializer

This block sits between a processing domain that runs five clock cycles per bunch crossing and an output domain that runs seven. During each crossing the processing logic hands over up to five result words through a write strobe. In the next crossing the block emits them on the output clock, one word per cycle. The output frame has seven slots, numbered 0 to 6. Slots 0 to 4 may carry words. Slots 5 and 6 are always idle, with valid low and data zero. A start pulse marks the word in slot 0.

Two banks of five words alternate. The writer fills one bank while the reader drains the other. Each domain receives its own crossing marker, a one-cycle pulse. The two clocks are phase related, and both markers are sampled on the shared rising edge that opens a crossing. Both markers swap the banks, so the two domains agree on which bank is being drained. Every word has been stable for at least one full processing cycle before the output side reads it.

When a crossing delivers fewer than five words, the empty slots are sent with valid low. Stale words from earlier crossings are never repeated. When an output frame ends without a new marker, the slot counter wraps and the following frame carries nothing.

Top module: `frac_rate_serializer`

## Requirements
- R1: While either reset is active, and until the first output marker is sampled, tx_valid and tx_start are low and tx_data is zero.
- R2: On the output clock edge that samples out_mark, the output becomes slot 0 of a new frame. Slots 0 to 4 carry, in write order, the words accepted in the processing crossing that ended on that same edge. The word for slot k is visible k cycles after that edge.
- R3: Slots 5 and 6 of every frame have tx_valid low and tx_data zero.
- R4: tx_start is high exactly in slot 0 of a marked frame that holds at least one word. It is low in every other cycle.
- R5: If a crossing delivered n words with n < 5, slots n to 4 of its frame have tx_valid low and tx_data zero.
- R6: A write strobe that arrives when five words have already been accepted since the last processing marker is dropped. The words already held are not changed.
- R7: After slot 6 the slot counter returns to 0 even without out_mark. A frame started this way has tx_valid low in all seven slots.
- R8: A write that shares a processing edge with proc_mark becomes the first word of the new crossing. Words written during a crossing never disturb the frame being emitted at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_proc | input | 1 | Processing clock, five cycles per crossing |
| rst_proc_n | input | 1 | Asynchronous active-low reset, processing domain |
| proc_mark | input | 1 | One-cycle pulse on the first processing cycle of a crossing |
| res_we | input | 1 | Write strobe for res_word |
| res_word | input | WORD_W | Result word to capture |
| clk_out | input | 1 | Output clock, seven cycles per crossing, phase aligned with clk_proc |
| rst_out_n | input | 1 | Asynchronous active-low reset, output domain |
| out_mark | input | 1 | One-cycle pulse on the first output cycle of a crossing |
| tx_data | output | WORD_W | Serialized result word, zero when idle |
| tx_valid | output | 1 | tx_data carries a result word |
| tx_start | output | 1 | First word of a crossing |

## Verification
Every output is registered, so the response to an out_mark sampled on an edge is visible right after that edge. The slot k word follows k edges later. The bench samples two nanoseconds after each output edge and compares against a model that is advanced on that same edge. The model also logs processing writes one nanosecond after each processing edge. Because of this ordering, the crossing closed on a shared edge is always logged before the output frame that reads it is checked.

// File: rtl/frs_pkg.sv
package frs_pkg;

   // Bit width needed to index v distinct values, never below one bit.
   function automatic int unsigned idx_bits(input int unsigned v);
      int unsigned b;
      b = $clog2(v);
      return (b < 1) ? 1 : b;
   endfunction

   // Bank identifier for the ping-pong store.
   typedef logic bank_sel_t;

endpackage

// File: rtl/frs_bank_writer.sv
module frs_bank_writer
   import frs_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned SLOTS  = 5,
   parameter int unsigned IDX_W  = idx_bits(SLOTS),
   parameter int unsigned CNT_W  = idx_bits(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mark,
   input  logic              we,
   input  logic [WORD_W-1:0] word,
   output logic              st_we,
   output bank_sel_t         st_bank,
   output logic [IDX_W-1:0]  st_idx,
   output logic [WORD_W-1:0] st_data,
   output logic              cnt_we,
   output bank_sel_t         cnt_bank,
   output logic [CNT_W-1:0]  cnt_val
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

   bank_sel_t        bank_q;
   logic [CNT_W-1:0] fill_q;
   bank_sel_t        cur_bank;
   logic [CNT_W-1:0] cur_fill;
   logic             room;

   always_comb begin
      cur_bank = mark ? ~bank_q : bank_q;
      cur_fill = mark ? '0 : fill_q;
      room     = (cur_fill < FULL);
      st_we    = we && room;
      st_bank  = cur_bank;
      st_idx   = cur_fill[IDX_W-1:0];
      st_data  = word;
      cnt_we   = mark || st_we;
      cnt_bank = cur_bank;
      cnt_val  = st_we ? (cur_fill + CNT_W'(1)) : cur_fill;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         fill_q <= '0;
      end else begin
         if (mark)   bank_q <= ~bank_q;
         if (cnt_we) fill_q <= cnt_val;
      end
   end

   AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FULL); // R6
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == FULL && !mark) |=> (fill_q == FULL)); // R6
   AST_MARK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (mark && !we) |=> (fill_q == '0)); // R8

endmodule

// File: rtl/frs_bank_store.sv
module frs_bank_store
   import frs_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned SLOTS  = 5,
   parameter int unsigned IDX_W  = idx_bits(SLOTS),
   parameter int unsigned CNT_W  = idx_bits(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_we,
   input  bank_sel_t         st_bank,
   input  logic [IDX_W-1:0]  st_idx,
   input  logic [WORD_W-1:0] st_data,
   input  logic              cnt_we,
   input  bank_sel_t         cnt_bank,
   input  logic [CNT_W-1:0]  cnt_val,
   input  bank_sel_t         rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word,
   output logic [CNT_W-1:0]  rd_cnt
);

   localparam int unsigned NBANK = 2;
   localparam logic [IDX_W-1:0] LIM = IDX_W'(SLOTS - 1);

   logic [WORD_W-1:0] mem_q [NBANK][SLOTS];
   logic [CNT_W-1:0]  cnt_q [NBANK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBANK; b++) begin
            cnt_q[b] <= '0;
            for (int s = 0; s < SLOTS; s++) mem_q[b][s] <= '0;
         end
      end else begin
         for (int b = 0; b < NBANK; b++) begin
            if (cnt_we && (int'(cnt_bank) == b)) cnt_q[b] <= cnt_val;
            for (int s = 0; s < SLOTS; s++) begin
               if (st_we && (int'(st_bank) == b) && (int'(st_idx) == s))
                  mem_q[b][s] <= st_data;
            end
         end
      end
   end

   always_comb begin
      rd_cnt  = cnt_q[rd_bank];
      rd_word = '0;
      if (rd_idx <= LIM) rd_word = mem_q[rd_bank][rd_idx];
   end

   AST_STORE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |-> (st_idx <= LIM)); // R6

endmodule

// File: rtl/frs_slot_reader.sv
module frs_slot_reader
   import frs_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned SLOTS     = 5,
   parameter int unsigned FRAME_LEN = 7,
   parameter bit          ZERO_IDLE = 1'b1,
   parameter int unsigned IDX_W     = idx_bits(SLOTS),
   parameter int unsigned CNT_W     = idx_bits(SLOTS + 1),
   parameter int unsigned SLOT_W    = idx_bits(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mark,
   input  logic [WORD_W-1:0] rd_word,
   input  logic [CNT_W-1:0]  rd_cnt,
   output bank_sel_t         rd_bank,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              tx_start
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
   localparam logic [SLOT_W-1:0] DATA_LIM  = SLOT_W'(SLOTS);

   logic [SLOT_W-1:0] slot_q, slot_n;
   logic              live_q, live_n;
   bank_sel_t         rbank_q;
   logic              vld_n, start_n;
   logic [WORD_W-1:0] data_n;

   always_comb begin
      if (mark) begin
         slot_n = '0;
         live_n = 1'b1;
      end else if (slot_q == LAST_SLOT) begin
         slot_n = '0;
         live_n = 1'b0;
      end else begin
         slot_n = slot_q + SLOT_W'(1);
         live_n = live_q;
      end
      rd_bank = mark ? rbank_q : ~rbank_q;
      rd_idx  = IDX_W'(slot_n);
      vld_n   = live_n && (slot_n < DATA_LIM) && (int'(slot_n) < int'(rd_cnt));
      start_n = vld_n && (slot_n == '0);
   end

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign data_n = vld_n ? rd_word : '0;
      end else begin : g_hold_idle
         assign data_n = vld_n ? rd_word : tx_data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q   <= LAST_SLOT;
         live_q   <= 1'b0;
         rbank_q  <= 1'b0;
         tx_data  <= '0;
         tx_valid <= 1'b0;
         tx_start <= 1'b0;
      end else begin
         slot_q   <= slot_n;
         live_q   <= live_n;
         if (mark) rbank_q <= ~rbank_q;
         tx_data  <= data_n;
         tx_valid <= vld_n;
         tx_start <= start_n;
      end
   end

   AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q >= DATA_LIM) |-> !tx_valid); // R3
   AST_START_IN_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (tx_valid && slot_q == '0)); // R4
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R4
   AST_MARK_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mark |=> (slot_q == '0 && live_q)); // R2
   AST_ORPHAN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !live_q |-> !tx_valid); // R7

   generate
      if (ZERO_IDLE) begin : g_idle_chk
         AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_valid |-> (tx_data == '0)); // R5
      end
   endgenerate

endmodule

// File: rtl/frac_rate_serializer.sv
module frac_rate_serializer
   import frs_pkg::*;
#(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned SLOTS     = 5,
   parameter int unsigned FRAME_LEN = 7,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              clk_proc,
   input  logic              rst_proc_n,
   input  logic              proc_mark,
   input  logic              res_we,
   input  logic [WORD_W-1:0] res_word,
   input  logic              clk_out,
   input  logic              rst_out_n,
   input  logic              out_mark,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              tx_start
);

   localparam int unsigned IDX_W  = idx_bits(SLOTS);
   localparam int unsigned CNT_W  = idx_bits(SLOTS + 1);
   localparam int unsigned SLOT_W = idx_bits(FRAME_LEN);

   initial begin
      assert (WORD_W >= 1) else $error("WORD_W must be at least 1");
      assert (SLOTS >= 1) else $error("SLOTS must be at least 1");
      assert (FRAME_LEN > SLOTS) else $error("FRAME_LEN must exceed SLOTS");
   end

   logic              st_we, cnt_we;
   bank_sel_t         st_bank, cnt_bank, rd_bank;
   logic [IDX_W-1:0]  st_idx, rd_idx;
   logic [WORD_W-1:0] st_data, rd_word;
   logic [CNT_W-1:0]  cnt_val, rd_cnt;

   frs_bank_writer #(.WORD_W(WORD_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_writer (
      .clk(clk_proc), .rst_n(rst_proc_n), .mark(proc_mark), .we(res_we), .word(res_word),
      .st_we(st_we), .st_bank(st_bank), .st_idx(st_idx), .st_data(st_data),
      .cnt_we(cnt_we), .cnt_bank(cnt_bank), .cnt_val(cnt_val));

   frs_bank_store #(.WORD_W(WORD_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
      .clk(clk_proc), .rst_n(rst_proc_n),
      .st_we(st_we), .st_bank(st_bank), .st_idx(st_idx), .st_data(st_data),
      .cnt_we(cnt_we), .cnt_bank(cnt_bank), .cnt_val(cnt_val),
      .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_word(rd_word), .rd_cnt(rd_cnt));

   frs_slot_reader #(.WORD_W(WORD_W), .SLOTS(SLOTS), .FRAME_LEN(FRAME_LEN), .ZERO_IDLE(ZERO_IDLE),
                     .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_reader (
      .clk(clk_out), .rst_n(rst_out_n), .mark(out_mark),
      .rd_word(rd_word), .rd_cnt(rd_cnt), .rd_bank(rd_bank), .rd_idx(rd_idx),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_start(tx_start));

endmodule

// File: tb/frac_rate_serializer_tb.sv
`timescale 1ns/1ps
module frac_rate_serializer_tb;

   localparam int W = 16;
   localparam int NX = 15;

   logic clk_proc = 1'b1, clk_out = 1'b1;
   logic rst_proc_n = 1'b0, rst_out_n = 1'b0;
   logic proc_mark = 1'b0, res_we = 1'b0, out_mark = 1'b0;
   logic [W-1:0] res_word = '0;
   logic [W-1:0] tx_data;
   logic tx_valid, tx_start;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #5 clk_out  = ~clk_out;   // 100 MHz, seven cycles per crossing
   always #7 clk_proc = ~clk_proc;  // five cycles per crossing, edges meet every 70 ns

   frac_rate_serializer #(.WORD_W(W)) u_dut (
      .clk_proc(clk_proc), .rst_proc_n(rst_proc_n), .proc_mark(proc_mark),
      .res_we(res_we), .res_word(res_word), .clk_out(clk_out), .rst_out_n(rst_out_n),
      .out_mark(out_mark), .tx_data(tx_data), .tx_valid(tx_valid), .tx_start(tx_start));

   // Stimulus plan per crossing: marker present, write mask over the five processing cycles.
   bit       plan_mark [NX];
   bit [4:0] plan_mask [NX];
   initial begin
      plan_mark = '{1,1,1,1,0,1,1,0,1,1,1,1,1,0,1};
      plan_mask = '{5'h1F,5'h07,5'h00,5'h1F,5'h1F,5'h0F,5'h15,5'h1E,5'h10,5'h1F,5'h0A,5'h00,5'h00,5'h00,5'h00};
   end

   task automatic check(input string req, input logic [W-1:0] ad, input logic av, input logic as,
                        input logic [W-1:0] ed, input logic ev, input logic es);
      n_chk++;
      if (ad !== ed || av !== ev || as !== es) begin
         n_err++;
         $display("FAIL %s t=%0t actual data=%h valid=%b start=%b expected data=%h valid=%b start=%b",
                  req, $time, ad, av, as, ed, ev, es);
      end
   endtask

   // Processing-domain reference: words accepted since the last marker.
   int  buf_q[$];
   bit  buf_drop = 0;
   int  done_w[$];
   bit  done_drop = 0;
   always begin
      @(posedge clk_proc); #1;
      if (rst_proc_n) begin
         if (proc_mark) begin
            done_w = buf_q; done_drop = buf_drop;
            buf_q = {}; buf_drop = 0;
         end
         if (res_we) begin
            if (buf_q.size() < 5) buf_q.push_back(int'(res_word));
            else buf_drop = 1;
         end
      end
   end

   // Output-domain reference, advanced and compared on every output edge.
   int  slot = 6;
   bit  live = 0, ever = 0, cur_drop = 0;
   int  cur_w[$];
   always begin
      @(posedge clk_out); #2;
      if (rst_out_n) begin
         logic ev, es;
         logic [W-1:0] ed;
         string req;
         if (out_mark) begin
            slot = 0; live = 1; ever = 1; cur_w = done_w; cur_drop = done_drop;
         end else if (slot == 6) begin
            slot = 0; live = 0;
         end else slot++;
         ev = live && slot < 5 && slot < cur_w.size();
         ed = ev ? W'(cur_w[slot]) : '0;
         es = ev && slot == 0;
         if (!ever) req = "R1";
         else if (!live) req = "R7";
         else if (slot >= 5) req = "R3";
         else if (slot == 0) req = "R4/R2";
         else if (!ev) req = "R5";
         else if (cur_drop) req = "R6";
         else req = "R2/R8";
         check(req, tx_data, tx_valid, tx_start, ed, ev, es);
      end
   end

   task automatic drive_proc();
      do @(posedge clk_proc); while ($time % 70 != 56);
      for (int m = 0; m < NX; m++) begin
         for (int p = 0; p < 5; p++) begin
            @(negedge clk_proc);
            proc_mark = plan_mark[m] && p == 0;
            res_we    = plan_mask[m][p];
            res_word  = W'(16'h1000 + m * 16 + p);
         end
      end
      @(negedge clk_proc);
      proc_mark = 0; res_we = 0;
   endtask

   task automatic drive_out();
      do @(posedge clk_out); while ($time % 70 != 60);
      for (int m = 0; m < NX; m++) begin
         for (int c = 0; c < 7; c++) begin
            @(negedge clk_out);
            out_mark = plan_mark[m] && c == 0;
         end
      end
      @(negedge clk_out);
      out_mark = 0;
   endtask

   initial begin
      fork
         begin
            #33;
            check("R1", tx_data, tx_valid, tx_start, '0, 1'b0, 1'b0);  // in reset
            rst_proc_n = 1; rst_out_n = 1;
            #70;
            fork drive_proc(); drive_out(); join
            repeat (16) @(posedge clk_out);
            done = 1;
         end
         begin
            #2000000;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
         end
      join_any
      #3;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule